// File: doc/BRIEF.md
# Timed-State Multicycle Processor Core

This block is a small 32-bit processor that runs every instruction as a short chain of numbered timing states. A program counter, an instruction register, a memory address register, a memory data register and a 32-entry register file are updated in fixed states. The first three states fetch the next word and are the same for every instruction. The states from the fourth one on depend on the opcode. Control goes back to the first fetch state once the last execute state of an instruction is done.

The core drives one memory port. The address always comes from the memory address register, and the write data always comes from the memory data register. A read strobe and a write strobe mark the cycles in which memory is used. Read data must be valid in the same cycle as the read strobe, and it is captured at the end of that cycle. A write takes effect at the clock edge that ends the cycle in which the write strobe is high.

Top module: `tstate_core`

## Requirements
- R1: While reset is low, both strobes are low and the memory address is zero. After reset is released, the first instruction is fetched from address 0.
- R2: Instruction word fields are: opcode in bits 31:26, destination in bits 25:21, first source in bits 20:16, second source in bits 15:11, 16-bit constant in bits 15:0 and 26-bit jump offset in bits 25:0. Fetch takes three states. In the second fetch state the read strobe is high with the address equal to PC. PC grows by 4 in the third fetch state.
- R3: Register-register operations take four states in total and write the destination with the result. The opcodes are 0x01 add, 0x02 subtract, 0x03 multiply (low 32 bits), 0x04 unsigned divide (a zero divisor gives all ones), 0x05 AND and 0x06 OR.
- R4: Constant operations take four states. The opcodes are 0x08 add and 0x09 subtract, both with a sign-extended constant, 0x0A AND and 0x0B OR, both with a zero-extended constant, and 0x0C shift left and 0x0D logical shift right, both by constant bits 4:0.
- R5: Load (0x10) takes six states. It reads the word at first source plus the sign-extended constant, with the read strobe high in the fifth state, and writes that word into the destination.
- R6: Store (0x11) takes six states. It writes the register named in bits 25:21 to first source plus the sign-extended constant. The write strobe is high only in its sixth state.
- R7: A conditional branch takes five states and compares the first source, as a signed number, with zero. The opcodes are 0x18 less than, 0x19 greater than, 0x1A equal and 0x1B not equal. When taken, the next instruction is at the branch address plus four times the sign-extended constant. Otherwise execution falls through.
- R8: A relative jump (0x20) takes four states and goes to its own address plus four times the sign-extended 26-bit offset. A register jump (0x21) takes four states and goes to first source plus the sign-extended constant.
- R9: Jump-and-link (0x22) takes five states. It writes its own address plus 4 into register 31 and jumps as a relative jump does.
- R10: Register 0 always reads as zero, even after an instruction writes to it.
- R11: Any other opcode takes four states and changes no register.
- R12: The read and write strobes are never high together. No write happens outside a store.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_addr | output | 32 | Memory byte address (memory address register) |
| mem_wdata | output | 32 | Store data (memory data register) |
| mem_rdata | input | 32 | Read data, valid in the strobe cycle |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |

## Verification
The properties assume that memory returns read data in the same cycle as the strobe and never stalls. Every state check therefore follows a fixed count of cycles, with no waiting on a response. They also assume the program stays inside the modelled memory. The stimulus is one straight program, placed in a zero-filled memory that answers combinationally, with stores aimed at a data area above the code. Skipped instructions and a backward loop are laid out so that control never leaves the code words.

// File: rtl/tsc_pkg.sv
`timescale 1ns/1ps
// Shared types for the timed-state core: timing states, instruction
// kinds, ALU operations and opcode values. Assumes a 6-bit opcode field.
package tsc_pkg;

    typedef enum logic [2:0] {PH_T0, PH_T1, PH_T2, PH_T3, PH_T4, PH_T5} tstate_e;

    typedef enum logic [3:0] {K_RR, K_RI, K_LD, K_ST, K_BR, K_J, K_JR, K_JAL, K_NOP} kind_e;

    typedef enum logic [2:0] {A_ADD, A_SUB, A_MUL, A_DIV, A_AND, A_OR, A_SHL, A_SHR} aluop_e;

    localparam logic [5:0] OPC_ADD  = 6'h01;
    localparam logic [5:0] OPC_SUB  = 6'h02;
    localparam logic [5:0] OPC_MUL  = 6'h03;
    localparam logic [5:0] OPC_DIV  = 6'h04;
    localparam logic [5:0] OPC_AND  = 6'h05;
    localparam logic [5:0] OPC_OR   = 6'h06;
    localparam logic [5:0] OPC_ADDI = 6'h08;
    localparam logic [5:0] OPC_SUBI = 6'h09;
    localparam logic [5:0] OPC_ANDI = 6'h0A;
    localparam logic [5:0] OPC_ORI  = 6'h0B;
    localparam logic [5:0] OPC_SHL  = 6'h0C;
    localparam logic [5:0] OPC_SHR  = 6'h0D;
    localparam logic [5:0] OPC_LD   = 6'h10;
    localparam logic [5:0] OPC_ST   = 6'h11;
    localparam logic [5:0] OPC_BLT  = 6'h18;
    localparam logic [5:0] OPC_BGT  = 6'h19;
    localparam logic [5:0] OPC_BEQ  = 6'h1A;
    localparam logic [5:0] OPC_BNE  = 6'h1B;
    localparam logic [5:0] OPC_J    = 6'h20;
    localparam logic [5:0] OPC_JR   = 6'h21;
    localparam logic [5:0] OPC_JAL  = 6'h22;

endpackage

// File: rtl/tsc_regfile.sv
`timescale 1ns/1ps
// Register file: two combinational read ports and one write port.
// Entry 0 is never written and always reads as zero. Assumes NREG is a power of two.
module tsc_regfile #(
    parameter int XLEN = 32,
    parameter int NREG = 32,
    parameter int AW   = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [AW-1:0]   wa,
    input  logic [XLEN-1:0] wd,
    input  logic [AW-1:0]   ra1,
    input  logic [AW-1:0]   ra2,
    output logic [XLEN-1:0] rd1,
    output logic [XLEN-1:0] rd2
);

    logic [XLEN-1:0] regs_q [NREG];

    // Clear on reset, then write one entry per cycle, skipping entry 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
        end else if (we && (wa != '0)) begin
            regs_q[wa] <= wd;
        end
    end

    // Read ports, with entry 0 forced to zero.
    always_comb begin
        rd1 = (ra1 == '0) ? '0 : regs_q[ra1];
        rd2 = (ra2 == '0) ? '0 : regs_q[ra2];
    end

endmodule

// File: rtl/tsc_alu.sv
`timescale 1ns/1ps
// Combinational ALU covering the register and constant operations.
// Division is unsigned; a zero divisor returns all ones.
module tsc_alu
    import tsc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  aluop_e          op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] y
);

    localparam int SW = $clog2(XLEN);

    // Select the result for the requested operation.
    always_comb begin
        case (op)
            A_ADD:   y = a + b;
            A_SUB:   y = a - b;
            A_MUL:   y = a * b;
            A_DIV:   y = (b == '0) ? '1 : a / b;
            A_AND:   y = a & b;
            A_OR:    y = a | b;
            A_SHL:   y = a << b[SW-1:0];
            default: y = a >> b[SW-1:0];
        endcase
    end

endmodule

// File: rtl/tsc_decode.sv
`timescale 1ns/1ps
// Instruction decoder: turns the instruction register into a kind, an ALU
// operation, register indices and the extended constants and offsets.
// Offsets are word offsets with 4 removed, because PC has already advanced.
module tsc_decode
    import tsc_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int AW   = 5
) (
    input  logic [31:0]     ir,
    output kind_e           kind,
    output aluop_e          alu_op,
    output logic            use_imm,
    output logic [1:0]      br_cond,
    output logic [AW-1:0]   rd_idx,
    output logic [AW-1:0]   rs1_idx,
    output logic [AW-1:0]   rs2_idx,
    output logic [XLEN-1:0] imm_ext,
    output logic [XLEN-1:0] br_off,
    output logic [XLEN-1:0] jmp_off
);

    logic [5:0] opc;
    logic       imm_signed;

    assign opc = ir[31:26];

    // Classify the opcode and choose the ALU operation and constant extension.
    always_comb begin
        kind       = K_NOP;
        alu_op     = A_ADD;
        use_imm    = 1'b0;
        imm_signed = 1'b1;
        case (opc)
            OPC_ADD:  begin kind = K_RR; alu_op = A_ADD; end
            OPC_SUB:  begin kind = K_RR; alu_op = A_SUB; end
            OPC_MUL:  begin kind = K_RR; alu_op = A_MUL; end
            OPC_DIV:  begin kind = K_RR; alu_op = A_DIV; end
            OPC_AND:  begin kind = K_RR; alu_op = A_AND; end
            OPC_OR:   begin kind = K_RR; alu_op = A_OR;  end
            OPC_ADDI: begin kind = K_RI; alu_op = A_ADD; use_imm = 1'b1; end
            OPC_SUBI: begin kind = K_RI; alu_op = A_SUB; use_imm = 1'b1; end
            OPC_ANDI: begin kind = K_RI; alu_op = A_AND; use_imm = 1'b1; imm_signed = 1'b0; end
            OPC_ORI:  begin kind = K_RI; alu_op = A_OR;  use_imm = 1'b1; imm_signed = 1'b0; end
            OPC_SHL:  begin kind = K_RI; alu_op = A_SHL; use_imm = 1'b1; imm_signed = 1'b0; end
            OPC_SHR:  begin kind = K_RI; alu_op = A_SHR; use_imm = 1'b1; imm_signed = 1'b0; end
            OPC_LD:   kind = K_LD;
            OPC_ST:   kind = K_ST;
            OPC_BLT, OPC_BGT, OPC_BEQ, OPC_BNE: kind = K_BR;
            OPC_J:    kind = K_J;
            OPC_JR:   kind = K_JR;
            OPC_JAL:  kind = K_JAL;
            default:  kind = K_NOP;
        endcase
    end

    // Extract register indices; a store reads its data register from the destination field.
    always_comb begin
        rd_idx  = ir[25:21];
        rs1_idx = ir[20:16];
        rs2_idx = (kind == K_ST) ? ir[25:21] : ir[15:11];
        br_cond = opc[1:0];
    end

    // Build the extended constant and the two control-transfer offsets.
    always_comb begin
        imm_ext = imm_signed ? {{(XLEN-16){ir[15]}}, ir[15:0]}
                             : {{(XLEN-16){1'b0}}, ir[15:0]};
        br_off  = ({{(XLEN-16){ir[15]}}, ir[15:0]} << 2) - XLEN'(4);
        jmp_off = ({{(XLEN-26){ir[25]}}, ir[25:0]} << 2) - XLEN'(4);
    end

endmodule

// File: rtl/tsc_seq.sv
`timescale 1ns/1ps
// Timing-state sequencer: three fetch states, then one to three execute
// states chosen by instruction kind, then back to the first fetch state.
module tsc_seq
    import tsc_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  kind_e   kind,
    output tstate_e state_q
);

    tstate_e state_d;

    // Pick the following timing state.
    always_comb begin
        case (state_q)
            PH_T0:   state_d = PH_T1;
            PH_T1:   state_d = PH_T2;
            PH_T2:   state_d = PH_T3;
            PH_T3:   state_d = (kind inside {K_LD, K_ST, K_BR, K_JAL}) ? PH_T4 : PH_T0;
            PH_T4:   state_d = (kind inside {K_LD, K_ST}) ? PH_T5 : PH_T0;
            default: state_d = PH_T0;
        endcase
    end

    // Hold the current timing state; reset enters the first fetch state.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PH_T0;
        else        state_q <= state_d;
    end

endmodule

// File: rtl/tstate_core.sv
`timescale 1ns/1ps
// Multicycle processor core with fixed register transfers per timing state.
// Assumes memory read data is valid in the same cycle as mem_rd and never stalls.
module tstate_core
    import tsc_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int NREG = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [XLEN-1:0] mem_addr,
    output logic [XLEN-1:0] mem_wdata,
    input  logic [XLEN-1:0] mem_rdata,
    output logic            mem_rd,
    output logic            mem_wr
);

    localparam int AW = $clog2(NREG);

    tstate_e         state_q;
    kind_e           kind;
    aluop_e          alu_op;
    logic            use_imm;
    logic [1:0]      br_cond;
    logic [AW-1:0]   rd_idx, rs1_idx, rs2_idx;
    logic [XLEN-1:0] imm_ext, br_off, jmp_off;
    logic [XLEN-1:0] pc_q, mar_q, mdr_q;
    logic [31:0]     ir_q;
    logic            take_q;
    logic            br_true;
    logic [XLEN-1:0] rs1_val, rs2_val, alu_b, alu_y;
    logic            rf_we;
    logic [AW-1:0]   rf_wa;
    logic [XLEN-1:0] rf_wd;

    tsc_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .kind    (kind),
        .state_q (state_q)
    );

    tsc_decode #(.XLEN(XLEN), .AW(AW)) u_dec (
        .ir      (ir_q),
        .kind    (kind),
        .alu_op  (alu_op),
        .use_imm (use_imm),
        .br_cond (br_cond),
        .rd_idx  (rd_idx),
        .rs1_idx (rs1_idx),
        .rs2_idx (rs2_idx),
        .imm_ext (imm_ext),
        .br_off  (br_off),
        .jmp_off (jmp_off)
    );

    tsc_regfile #(.XLEN(XLEN), .NREG(NREG), .AW(AW)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (rf_we),
        .wa    (rf_wa),
        .wd    (rf_wd),
        .ra1   (rs1_idx),
        .ra2   (rs2_idx),
        .rd1   (rs1_val),
        .rd2   (rs2_val)
    );

    assign alu_b = use_imm ? imm_ext : rs2_val;

    tsc_alu #(.XLEN(XLEN)) u_alu (
        .op (alu_op),
        .a  (rs1_val),
        .b  (alu_b),
        .y  (alu_y)
    );

    // Evaluate the branch condition on the first source, as signed, against zero.
    always_comb begin
        case (br_cond)
            2'd0:    br_true = rs1_val[XLEN-1];
            2'd1:    br_true = !rs1_val[XLEN-1] && (|rs1_val);
            2'd2:    br_true = ~|rs1_val;
            default: br_true = |rs1_val;
        endcase
    end

    // Apply the register transfers fixed to each timing state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q   <= '0;
            mar_q  <= '0;
            mdr_q  <= '0;
            ir_q   <= '0;
            take_q <= 1'b0;
        end else begin
            case (state_q)
                PH_T0: mar_q <= pc_q;
                PH_T1: mdr_q <= mem_rdata;
                PH_T2: begin
                    ir_q <= mdr_q[31:0];
                    pc_q <= pc_q + XLEN'(4);
                end
                PH_T3: begin
                    case (kind)
                        K_LD, K_ST: mar_q  <= rs1_val + imm_ext;
                        K_BR:       take_q <= br_true;
                        K_J:        pc_q   <= pc_q + jmp_off;
                        K_JR:       pc_q   <= rs1_val + imm_ext;
                        default: ;
                    endcase
                end
                PH_T4: begin
                    case (kind)
                        K_LD:    mdr_q <= mem_rdata;
                        K_ST:    mdr_q <= rs2_val;
                        K_BR:    if (take_q) pc_q <= pc_q + br_off;
                        K_JAL:   pc_q  <= pc_q + jmp_off;
                        default: ;
                    endcase
                end
                default: ;
            endcase
        end
    end

    // Register-file write port: ALU results and the link in T3, load data in T5.
    always_comb begin
        rf_we = ((state_q == PH_T3) && (kind inside {K_RR, K_RI, K_JAL}))
             || ((state_q == PH_T5) && (kind == K_LD));
        rf_wa = (kind == K_JAL) ? AW'(NREG - 1) : rd_idx;
        if (kind == K_JAL)     rf_wd = pc_q;
        else if (kind == K_LD) rf_wd = mdr_q;
        else                   rf_wd = alu_y;
    end

    // Memory port strobes and buses.
    always_comb begin
        mem_addr  = mar_q;
        mem_wdata = mdr_q;
        mem_rd    = (state_q == PH_T1) || ((state_q == PH_T4) && (kind == K_LD));
        mem_wr    = (state_q == PH_T5) && (kind == K_ST);
    end

endmodule

// File: rtl/tstate_core_chk.sv
`timescale 1ns/1ps
// Property checker for the timed-state core, bound to its internal state and PC.
module tstate_core_chk
    import tsc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input tstate_e         state_q,
    input logic [XLEN-1:0] pc_q,
    input logic            mem_rd,
    input logic            mem_wr
);

    // R12
    rw_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R6
    wr_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (state_q == PH_T5));

    // R2
    fetch_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_T1) |-> mem_rd);

    // R2
    fetch_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_T1) |=> (state_q == PH_T2));

    // R2
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_T2) |=> (pc_q == $past(pc_q) + XLEN'(4)));

    // R5
    exec_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_T5) |=> (state_q == PH_T0));

endmodule

bind tstate_core tstate_core_chk #(.XLEN(XLEN)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .state_q (state_q),
    .pc_q    (pc_q),
    .mem_rd  (mem_rd),
    .mem_wr  (mem_wr)
);

// File: tb/tstate_core_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver places a program in memory and queues the
// expected stores; the monitor compares each write (address, data, cycle).
module tstate_core_tb_top;

    localparam int MEMW = 256;

    typedef struct {
        logic [31:0] addr;
        logic [31:0] data;
        int          cyc;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_rd, mem_wr;
    logic [31:0] mem [MEMW];

    int   n_chk = 0;
    int   n_bad = 0;
    int   cyc = 0;
    int   n_overlap = 0;
    int   pcw = 0;
    int   tcyc = 0;
    int   slot = 0;
    exp_t q[$];
    exp_t cur;

    always #4 clk = ~clk;

    assign mem_rdata = mem[mem_addr[9:2]];

    // Memory write port model.
    always @(posedge clk) if (mem_wr) mem[mem_addr[9:2]] = mem_wdata;

    tstate_core dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic report();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    function automatic logic [31:0] enc_r(logic [5:0] op, int rd, int rs1, int rs2);
        return {op, 5'(rd), 5'(rs1), 5'(rs2), 11'd0};
    endfunction

    function automatic logic [31:0] enc_i(logic [5:0] op, int rd, int rs1, logic [15:0] imm);
        return {op, 5'(rd), 5'(rs1), imm};
    endfunction

    function automatic logic [31:0] enc_j(logic [5:0] op, logic [25:0] off);
        return {op, off};
    endfunction

    // Place an executed instruction and add its state count.
    task automatic put(input logic [31:0] w, input int states);
        mem[pcw >> 2] = w;
        pcw  += 4;
        tcyc += states;
    endtask

    // Place an instruction that control flow jumps over.
    task automatic skip(input logic [31:0] w);
        mem[pcw >> 2] = w;
        pcw += 4;
    endtask

    // Store a register to the next data slot and queue the expected write (T5 of the store).
    task automatic st_exp(input int src, input logic [31:0] val, input string tag);
        logic [31:0] a;
        a = 32'h200 + 32'(slot * 4);
        q.push_back('{addr: a, data: val, cyc: tcyc + 5, tag: tag});
        put(enc_i(6'h11, src, 0, a[15:0]), 6);
        slot++;
    endtask

    // Driver: build the program and expectations, then run reset and wait for completion.
    initial begin
        int jal_at;
        int p;
        for (int i = 0; i < MEMW; i++) mem[i] = 32'h0;

        put(enc_i(6'h08, 1, 0, 16'd7), 4);
        put(enc_i(6'h08, 2, 0, 16'hFFFD), 4);
        put(enc_i(6'h0B, 3, 0, 16'hF00F), 4);
        put(enc_r(6'h01, 4, 1, 2), 4);  st_exp(4, 32'd4, "R3");
        put(enc_r(6'h02, 5, 1, 2), 4);  st_exp(5, 32'd10, "R3");
        put(enc_r(6'h03, 6, 1, 2), 4);  st_exp(6, 32'hFFFF_FFEB, "R3");
        put(enc_r(6'h04, 7, 3, 1), 4);  st_exp(7, 32'd8779, "R3");
        put(enc_r(6'h04, 8, 1, 0), 4);  st_exp(8, 32'hFFFF_FFFF, "R3");
        put(enc_r(6'h05, 9, 3, 2), 4);  st_exp(9, 32'h0000_F00D, "R3");
        put(enc_i(6'h0C, 11, 1, 16'd4), 4);  st_exp(11, 32'h70, "R4");
        put(enc_i(6'h0D, 12, 2, 16'd28), 4); st_exp(12, 32'hF, "R4");
        put(enc_i(6'h09, 13, 1, 16'd10), 4); st_exp(13, 32'hFFFF_FFFD, "R4");
        put(enc_i(6'h0A, 14, 2, 16'h8001), 4); st_exp(14, 32'h0000_8001, "R4");
        st_exp(3, 32'h0000_F00F, "R4");
        put(enc_r(6'h06, 10, 11, 1), 4); st_exp(10, 32'h77, "R3");
        put(enc_i(6'h08, 0, 0, 16'd5), 4); st_exp(0, 32'h0, "R10");
        // loads from the first data slot, which holds 4
        put(enc_i(6'h10, 15, 0, 16'h0200), 6);
        put(enc_r(6'h01, 16, 15, 15), 4); st_exp(16, 32'd8, "R5");
        put(enc_i(6'h08, 17, 0, 16'h0210), 4);
        put(enc_i(6'h10, 18, 17, 16'hFFF0), 6); st_exp(18, 32'd4, "R5");
        // branches
        put(enc_i(6'h1A, 0, 0, 16'd2), 5); skip(enc_i(6'h08, 20, 0, 16'd1)); st_exp(20, 32'd0, "R7");
        put(enc_i(6'h1B, 0, 0, 16'd2), 5); put(enc_i(6'h08, 21, 0, 16'd2), 4); st_exp(21, 32'd2, "R7");
        put(enc_i(6'h18, 0, 2, 16'd2), 5); skip(enc_i(6'h08, 22, 0, 16'd9)); st_exp(22, 32'd0, "R7");
        put(enc_i(6'h19, 0, 2, 16'd2), 5); put(enc_i(6'h08, 23, 0, 16'd3), 4); st_exp(23, 32'd3, "R7");
        put(enc_i(6'h19, 0, 1, 16'd3), 5); skip(enc_i(6'h08, 24, 0, 16'd5));
        skip(enc_i(6'h08, 24, 0, 16'd5)); st_exp(24, 32'd0, "R7");
        put(enc_i(6'h18, 0, 1, 16'd2), 5); put(enc_i(6'h08, 25, 0, 16'd6), 4); st_exp(25, 32'd6, "R7");
        put(enc_i(6'h1A, 0, 1, 16'd2), 5); put(enc_i(6'h08, 28, 0, 16'd11), 4); st_exp(28, 32'd11, "R7");
        // backward loop: three decrements, two taken branches and one fall-through
        put(enc_i(6'h08, 29, 0, 16'd3), 4);
        put(enc_i(6'h09, 29, 29, 16'd1), 4);
        put(enc_i(6'h1B, 0, 29, 16'hFFFF), 5);
        tcyc += 2 * (4 + 5);
        st_exp(29, 32'd0, "R7");
        // jumps
        put(enc_j(6'h20, 26'd2), 4); skip(enc_i(6'h08, 25, 0, 16'd1)); st_exp(25, 32'd6, "R8");
        jal_at = pcw;
        put(enc_j(6'h22, 26'd2), 5); skip(enc_i(6'h08, 30, 0, 16'd1));
        st_exp(31, 32'(jal_at + 4), "R9");
        st_exp(30, 32'd0, "R9");
        p = pcw;
        put(enc_i(6'h08, 26, 0, 16'(p + 4)), 4);
        put(enc_i(6'h21, 0, 26, 16'd8), 4); skip(enc_i(6'h08, 27, 0, 16'd1));
        st_exp(27, 32'd0, "R8");
        // unrecognised opcode
        put(32'hFFFF_FFFF, 4); st_exp(1, 32'd7, "R11");
        st_exp(31, 32'(jal_at + 4), "R11");
        // park in a jump to itself
        put(enc_j(6'h20, 26'd0), 4);

        repeat (3) @(negedge clk);
        check(mem_rd === 1'b0, "R1", "read strobe in reset", 32'(mem_rd), 32'd0);
        check(mem_wr === 1'b0, "R1", "write strobe in reset", 32'(mem_wr), 32'd0);
        check(mem_addr === 32'd0, "R1", "address in reset", mem_addr, 32'd0);
        #2 rst_n = 1'b1;

        wait (q.size() == 0);
        repeat (40) @(negedge clk);
        check(q.size() == 0, "R6", "pending stores", 32'(q.size()), 32'd0);
        check(n_overlap == 0, "R12", "strobe overlap cycles", 32'(n_overlap), 32'd0);
        report();
    end

    // Monitor: count cycles since reset and compare each write against the queue.
    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (cyc == 1) begin
                check(mem_rd === 1'b1, "R2", "first fetch strobe", 32'(mem_rd), 32'd1);
                check(mem_addr === 32'd0, "R1", "first fetch address", mem_addr, 32'd0);
            end
            if (mem_rd && mem_wr) n_overlap++;
            if (mem_wr) begin
                if (q.size() == 0) begin
                    check(1'b0, "R12", "unexpected write", mem_addr, 32'd0);
                end else begin
                    cur = q.pop_front();
                    check(mem_addr === cur.addr, cur.tag, "store address", mem_addr, cur.addr);
                    check(mem_wdata === cur.data, cur.tag, "store data", mem_wdata, cur.data);
                    check(cyc == cur.cyc, cur.tag, "store cycle", 32'(cyc), 32'(cur.cyc));
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (6000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d pending expected 0", q.size());
        report();
    end

endmodule